// File: doc/BRIEF.md
# Serial Command-Port Byte Memory

This block is the synchronous serial front end of a small byte-wide memory that is driven by commands. A host clocks bytes in on a data input, one bit per rising edge of the serial clock. Two select lines tell the block what each byte means: a data/command line and a read/write line. The block counts the bits. On the eighth edge of every byte it does one of four things. It stores a pointer byte, it writes memory at the pointer, it loads the checksum for reading, or it loads the addressed memory byte for reading. The pointer advances after every data byte, in either direction. A running XOR checksum covers all data moved since the pointer was last set.

A byte that is loaded for reading leaves the device most significant bit first during the following eight clocks. Every read therefore runs one byte behind the command that fetched it. Several devices can share one loop: the serial output of each feeds the serial input of the next, and only one device is selected at a time. A device that is not selected copies its serial input to its serial output, so the loop stays closed.

Top module: `sram_serial_port`

## Requirements
- R1: After reset the pointer is 0, the checksum is 0 and the shift register is 0. A device that is selected right after reset shows 0 on `sdo` before its first clock edge, and its first checksum read returns 0x00.
- R2: The serial port is active only when `par_mode` is 0, `cs_n` is 0 and `cs` is 1. While the port is inactive, `sdo` equals `sdi` combinationally.
- R3: Command writes (`rd_sel`=0, `dat_sel`=0) go to slots in a fixed cycle: pointer bits 7:0, then 15:8, then 23:16, then a fourth slot whose byte is discarded, and then back to bits 7:0. Memory is addressed by the low `ADDR_W` pointer bits.
- R4: On the eighth edge of a data write (`rd_sel`=0, `dat_sel`=1), the byte stored at the pointer is the seven bits shifted in earlier followed by the live `sdi` bit. The first bit sent is bit 7. The pointer then increments by one.
- R5: On the eighth edge of a data read (`rd_sel`=1, `dat_sel`=1), the byte at the pointer is loaded and the pointer increments. That byte appears on `sdo` bit 7 first during the next byte. `sdo` changes after each rising edge, so the first byte of any read sequence is a dummy.
- R6: The checksum is the XOR of every data byte written or read since the last command write to a pointer slot. Such a write clears it. A checksum read (`rd_sel`=1, `dat_sel`=0) loads it for shifting out.
- R7: A data read resets the command slot cycle, so the next command write goes to pointer bits 7:0.
- R8: When the port is inactive at a clock edge, the bit counter and the command slot reset. A partial byte is then discarded, and the next selection starts at bit 0 and slot 0.
- R9: A checksum read leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_mode | input | 1 | 1 selects the parallel bus; the serial port is then inactive |
| cs_n | input | 1 | Active-low chip select |
| cs | input | 1 | Active-high chip select |
| dat_sel | input | 1 | 1 = memory data, 0 = command/checksum |
| rd_sel | input | 1 | 1 = read, 0 = write |
| sdi | input | 1 | Serial data in, most significant bit first |
| sdo | output | 1 | Serial data out, or `sdi` copied through when inactive |

## Verification
The memory is written at addresses chosen so that both the low and the middle pointer byte decide where a byte lands. The write bytes 0x01 and 0x80 show whether bit order and the live eighth bit are handled right. Read-back sequences run one byte behind, with checksum reads as dummies. This shows the one-byte lag and shows that the pointer holds still across a checksum read. Command bursts that reach the discarded fourth slot, data reads followed by a lone command, and partial bytes cut off by a deselect each land data at an address that differs from the one a faulty slot or counter reset would pick. The copy-through path is tried with each of the three select conditions false.

// File: rtl/srcp_pkg.sv
`timescale 1ns/1ps
package srcp_pkg;
   localparam int BYTE_W = 8;
   localparam int CNT_W  = $clog2(BYTE_W);
   typedef logic [BYTE_W-1:0] byte_t;
   // operation encoding is {rd_sel, dat_sel}
   typedef enum logic [1:0] {
      OP_CMD_WR = 2'b00,
      OP_DAT_WR = 2'b01,
      OP_CHK_RD = 2'b10,
      OP_DAT_RD = 2'b11
   } op_e;
endpackage

// File: rtl/ssp_shifter.sv
`timescale 1ns/1ps
module ssp_shifter
   import srcp_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             sdi,
   input  logic             load_en,
   input  byte_t            load_val,
   output byte_t            sh,
   output byte_t            wr_byte,
   output logic [CNT_W-1:0] cnt,
   output logic             frame_end
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

   assign wr_byte   = {sh[BYTE_W-2:0], sdi};
   assign frame_end = active && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         cnt <= '0;
      end else if (!active) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
         sh  <= (frame_end && load_en) ? load_val : wr_byte;
      end
   end
endmodule

// File: rtl/ssp_pointer.sv
`timescale 1ns/1ps
module ssp_pointer
   import srcp_pkg::*;
#(
   parameter int PTR_BYTES = 3,
   parameter int SLOT_W    = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      active,
   input  logic                      frame_end,
   input  op_e                       op,
   input  byte_t                     wr_byte,
   input  byte_t                     rd_byte,
   output logic [PTR_BYTES*BYTE_W-1:0] ptr,
   output byte_t                     chk,
   output logic [SLOT_W-1:0]         slot
);
   localparam int PTR_W = PTR_BYTES * BYTE_W;
   localparam logic [SLOT_W-1:0] DISCARD_SLOT = SLOT_W'(PTR_BYTES);

   logic             step, cmd_wr, dat_rd;
   logic [PTR_W-1:0] ptr_inc;

   assign dat_rd  = frame_end && (op == OP_DAT_RD);
   assign step    = frame_end && (op == OP_DAT_RD || op == OP_DAT_WR);
   assign cmd_wr  = frame_end && (op == OP_CMD_WR);
   assign ptr_inc = ptr + PTR_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (step) begin
         ptr <= ptr_inc;
      end else if (cmd_wr) begin
         for (int g = 0; g < PTR_BYTES; g++) begin
            if (slot == SLOT_W'(g)) ptr[g*BYTE_W +: BYTE_W] <= wr_byte;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot <= '0;
      else if (!active) slot <= '0;
      else if (dat_rd)  slot <= '0;
      else if (cmd_wr)  slot <= (slot == DISCARD_SLOT) ? '0 : slot + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               chk <= '0;
      else if (cmd_wr && slot < DISCARD_SLOT)   chk <= '0;
      else if (step)                            chk <= chk ^ (dat_rd ? rd_byte : wr_byte);
   end
endmodule

// File: rtl/ssp_mem.sv
`timescale 1ns/1ps
module ssp_mem
   import srcp_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  byte_t             wdata,
   output byte_t             rdata
);
   localparam int DEPTH = 1 << ADDR_W;
   byte_t mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end
   assign rdata = mem[addr];
endmodule

// File: rtl/sram_serial_port.sv
`timescale 1ns/1ps
module sram_serial_port
   import srcp_pkg::*;
#(
   parameter int PTR_BYTES = 3,
   parameter int ADDR_W    = 10
) (
   input  logic sclk,
   input  logic rst_n,
   input  logic par_mode,
   input  logic cs_n,
   input  logic cs,
   input  logic dat_sel,
   input  logic rd_sel,
   input  logic sdi,
   output logic sdo
);
   localparam int PTR_W  = PTR_BYTES * BYTE_W;
   localparam int SLOT_W = $clog2(PTR_BYTES + 1);

   generate
      if (PTR_BYTES < 1) begin : g_bad_ptr
         $error("PTR_BYTES must be at least 1");
      end
      if (ADDR_W < 1 || ADDR_W > PTR_W) begin : g_bad_addr
         $error("ADDR_W must lie between 1 and the pointer width");
      end
   endgenerate

   logic             active, frame_end, load_en, mem_we;
   op_e              op;
   byte_t            sh, wr_byte, chk, mem_q, load_val;
   logic [CNT_W-1:0] cnt;
   logic [PTR_W-1:0] ptr;
   logic [SLOT_W-1:0] slot;

   assign active   = !par_mode && !cs_n && cs;
   assign op       = op_e'({rd_sel, dat_sel});
   assign load_en  = rd_sel;
   assign load_val = dat_sel ? mem_q : chk;
   assign mem_we   = frame_end && (op == OP_DAT_WR);
   assign sdo      = active ? sh[BYTE_W-1] : sdi;

   ssp_shifter u_shift (
      .clk(sclk), .rst_n(rst_n), .active(active), .sdi(sdi),
      .load_en(load_en), .load_val(load_val), .sh(sh), .wr_byte(wr_byte),
      .cnt(cnt), .frame_end(frame_end)
   );

   ssp_pointer #(.PTR_BYTES(PTR_BYTES), .SLOT_W(SLOT_W)) u_ptr (
      .clk(sclk), .rst_n(rst_n), .active(active), .frame_end(frame_end),
      .op(op), .wr_byte(wr_byte), .rd_byte(mem_q), .ptr(ptr), .chk(chk),
      .slot(slot)
   );

   ssp_mem #(.ADDR_W(ADDR_W)) u_mem (
      .clk(sclk), .we(mem_we), .addr(ptr[ADDR_W-1:0]), .wdata(wr_byte),
      .rdata(mem_q)
   );
endmodule

// File: rtl/ssp_checker.sv
`timescale 1ns/1ps
module ssp_checker #(
   parameter int PTR_BYTES = 3,
   parameter int PTR_W     = 24,
   parameter int SLOT_W    = 2,
   parameter int CNT_W     = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              active,
   input logic [CNT_W-1:0]  cnt,
   input logic              frame_end,
   input logic              rd,
   input logic              dat,
   input logic [SLOT_W-1:0] slot,
   input logic [PTR_W-1:0]  ptr,
   input logic [7:0]        chk,
   input logic              sdo,
   input logic [7:0]        mem_q
);
   assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (cnt == '0 && slot == '0));

   assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && dat) |=> ptr == PTR_W'($past(ptr) + 1'b1));

   assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && rd && !dat) |=> $stable(ptr));

   assert_chk_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && !rd && !dat && slot < SLOT_W'(PTR_BYTES)) |=> chk == 8'h00);

   assert_slot_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && rd && dat) |=> slot == '0);

   assert_read_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && rd && dat) |=> (!active || sdo == $past(mem_q[7])));
endmodule

bind sram_serial_port ssp_checker #(
   .PTR_BYTES(PTR_BYTES), .PTR_W(PTR_W), .SLOT_W(SLOT_W), .CNT_W(srcp_pkg::CNT_W)
) chk_i (
   .clk(sclk), .rst_n(rst_n), .active(active), .cnt(cnt),
   .frame_end(frame_end), .rd(rd_sel), .dat(dat_sel), .slot(slot),
   .ptr(ptr), .chk(chk), .sdo(sdo), .mem_q(mem_q)
);

// File: tb/sram_serial_port_tb_top.sv
`timescale 1ns/1ps
module sram_serial_port_tb_top;
   logic clk = 1'b0, rst_n = 1'b0;
   logic par_mode = 1'b0, cs_n = 1'b1, cs = 1'b1;
   logic dat_sel = 1'b0, rd_sel = 1'b0, sdi = 1'b0;
   logic sdo;
   int   n_chk = 0, n_err = 0, frame_no = 0;
   bit   done = 1'b0;
   logic [7:0] rx_last;
   event frame_done;

   typedef struct { int frame; logic [7:0] val; string req; } exp_t;
   exp_t exp_q[$];

   always #2 clk = ~clk;

   sram_serial_port dut_i (
      .sclk(clk), .rst_n(rst_n), .par_mode(par_mode), .cs_n(cs_n), .cs(cs),
      .dat_sel(dat_sel), .rd_sel(rd_sel), .sdi(sdi), .sdo(sdo)
   );

   task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one byte while selected; sdo sampled 1 ns after each falling edge
   task automatic frame(input logic rw, input logic dc, input logic [7:0] tx);
      logic [7:0] rx;
      for (int i = 7; i >= 0; i--) begin
         @(negedge clk);
         par_mode = 1'b0; cs = 1'b1; cs_n = 1'b0;
         rd_sel = rw; dat_sel = dc; sdi = tx[i];
         #1 rx[i] = sdo;
      end
      @(posedge clk);
      rx_last = rx;
      frame_no++;
      -> frame_done;
   endtask

   task automatic expect_next(input logic [7:0] v, input string req);
      exp_t e;
      e.frame = frame_no + 1; e.val = v; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic desel();
      @(negedge clk); cs_n = 1'b1;
      @(posedge clk);
   endtask

   task automatic cmd3(input logic [7:0] lo, input logic [7:0] mid, input logic [7:0] hi);
      frame(1'b0, 1'b0, lo); frame(1'b0, 1'b0, mid); frame(1'b0, 1'b0, hi);
   endtask

   // monitor: compares each byte shifted out against the queued expectation
   initial forever begin
      @(frame_done);
      if (exp_q.size() > 0 && exp_q[0].frame == frame_no) begin
         exp_t e;
         e = exp_q.pop_front();
         check(rx_last === e.val, e.req, rx_last, e.val);
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1: sdo of a freshly selected device
      @(negedge clk); cs_n = 1'b0; #1;
      check(sdo === 1'b0, "R1 sdo after reset", {7'b0, sdo}, 8'h00);
      cs_n = 1'b1;
      @(posedge clk);
      frame(1'b1, 1'b0, 8'h00); expect_next(8'h00, "R1 checksum after reset");
      frame(1'b1, 1'b0, 8'h00);
      desel();

      // R2: copy-through with each select condition false
      @(negedge clk);
      cs_n = 1'b1; sdi = 1'b1; #0.5;
      check(sdo === 1'b1, "R2 cs_n high", {7'b0, sdo}, 8'h01);
      sdi = 1'b0; #0.3;
      check(sdo === 1'b0, "R2 cs_n high", {7'b0, sdo}, 8'h00);
      cs_n = 1'b0; cs = 1'b0; sdi = 1'b1; #0.3;
      check(sdo === 1'b1, "R2 cs low", {7'b0, sdo}, 8'h01);
      cs = 1'b1; par_mode = 1'b1; sdi = 1'b0; #0.3;
      check(sdo === 1'b0, "R2 parallel mode", {7'b0, sdo}, 8'h00);
      @(posedge clk);
      @(negedge clk); par_mode = 1'b0; cs_n = 1'b1;
      @(posedge clk);

      // R3/R4: write 0xC3 at 0x005, then 5A 01 80 at 0x205..0x207
      cmd3(8'h05, 8'h00, 8'h00);
      frame(1'b0, 1'b1, 8'hC3);
      desel();
      cmd3(8'h05, 8'h02, 8'h00);
      frame(1'b0, 1'b1, 8'h5A);
      frame(1'b0, 1'b1, 8'h01);
      frame(1'b0, 1'b1, 8'h80);
      frame(1'b1, 1'b0, 8'h00); expect_next(8'hDB, "R6 write checksum");
      frame(1'b1, 1'b0, 8'h00);
      desel();

      // R5/R6/R9: read back one byte behind, checksum read in front
      cmd3(8'h05, 8'h02, 8'h00);
      frame(1'b1, 1'b0, 8'h00); expect_next(8'h00, "R6 cleared by pointer write");
      frame(1'b1, 1'b1, 8'h00); expect_next(8'h5A, "R9 pointer held over checksum read");
      frame(1'b1, 1'b1, 8'h00); expect_next(8'h01, "R5 second read byte");
      frame(1'b1, 1'b1, 8'h00); expect_next(8'h80, "R5 third read byte");
      frame(1'b1, 1'b0, 8'h00); expect_next(8'hDB, "R6 read checksum");
      frame(1'b1, 1'b0, 8'h00);
      // R7: lone command after a data read lands in bits 7:0 -> 0x209
      frame(1'b0, 1'b0, 8'h09);
      frame(1'b0, 1'b1, 8'h77);
      desel();

      // R3: fourth slot discarded, fifth wraps to bits 7:0 -> 0x140
      cmd3(8'h30, 8'h01, 8'h00);
      frame(1'b0, 1'b0, 8'hEE);
      frame(1'b0, 1'b0, 8'h40);
      frame(1'b0, 1'b1, 8'h99);
      desel();

      // R8: partial byte and half-done slot cycle cut off by deselect
      frame(1'b0, 1'b0, 8'h60);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); cs_n = 1'b0; rd_sel = 1'b0; dat_sel = 1'b1; sdi = 1'b1;
         @(posedge clk);
      end
      desel();
      cmd3(8'h50, 8'h00, 8'h00);
      frame(1'b0, 1'b1, 8'h11);
      desel();

      // read-backs
      cmd3(8'h40, 8'h01, 8'h00);
      frame(1'b1, 1'b1, 8'h00); expect_next(8'h99, "R3 wrap after discarded slot");
      frame(1'b1, 1'b0, 8'h00);
      desel();
      cmd3(8'h50, 8'h00, 8'h00);
      frame(1'b1, 1'b1, 8'h00); expect_next(8'h11, "R8 realigned after deselect");
      frame(1'b1, 1'b0, 8'h00);
      desel();
      cmd3(8'h09, 8'h02, 8'h00);
      frame(1'b1, 1'b1, 8'h00); expect_next(8'h77, "R7 slot reset by data read");
      frame(1'b1, 1'b0, 8'h00);
      desel();
      cmd3(8'h05, 8'h00, 8'h00);
      frame(1'b1, 1'b1, 8'h00); expect_next(8'hC3, "R3 middle pointer byte");
      frame(1'b1, 1'b0, 8'h00);
      desel();

      repeat (2) @(posedge clk);
      check(exp_q.size() == 0, "R5 all expected bytes seen", 8'(exp_q.size()), 8'h00);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule